// File: doc/BRIEF.md
# Quad SPI execute-in-place read sequencer

This block is the host side of a four-line serial NOR flash read path. A client hands it a read request (24-bit byte address, byte count, and a flag saying whether the flash should stay in continuous-read mode). It then runs one chip-select-framed transaction using the aligned quad-I/O read command, which has no dummy clocks, and returns the received bytes on a valid/ready byte stream. The serial clock runs at half the system clock in SPI mode 0.

The command byte goes out on one data line only. The address and an 8-bit mode value follow four bits per clock. Read data then comes back four bits per clock. The sequencer remembers the mode value it sent last. When that value left the flash in continuous-read mode, the next read starts directly with the address and saves eight serial clocks. A separate exit request sends eight clocks of all-ones on the lowest data line, which takes the flash out of that mode, and it clears the remembered state. A request address is rounded down to a multiple of 16, because this command needs the low four address bits to be zero.

Top module: `qspi_xip_reader`

## Requirements
- R1: When continuous-read mode is not in effect, a read starts with command byte 0xE3, sent MSB first over 8 serial clocks on io[0], with io_oe = 4'b0001 during those clocks.
- R2: The address follows in 6 serial clocks, one nibble per clock, starting with bits 23..20; within each nibble io[3] carries the most significant bit, and io_oe = 4'b1111.
- R3: The address sent is the request address rounded down to a multiple of 16: the sixth address nibble is always 4'h0.
- R4: With no dummy clocks between them, 2 mode clocks follow the address on all four lines: the mode byte is 0x20 when req_keep is 1 and 0x00 when it is 0, with the high nibble sent first.
- R5: After the mode clocks, req_len bytes are read in 2*req_len serial clocks, high nibble first and in ascending address order. They appear on rd_data in that order, so a full read lasts exactly 16 + 2*req_len serial clocks.
- R6: After a read sent with req_keep = 1, the next read sends no command byte. It starts with the address and lasts 8 + 2*req_len serial clocks.
- R7: After a read sent with req_keep = 0, or after an exit request, the next read carries the command byte again. An exit request (req_exit = 1) lasts exactly 8 serial clocks, with io[0] = 1 and io_oe = 4'b0001 on every clock.
- R8: io_oe is 4'b0000 from the falling clock edge that ends the second mode clock until chip select goes high.
- R9: Chip select stays high for at least 2 system clocks between transactions.
- R10: req_ready is low from the cycle after a request is accepted until that transaction has ended, so a request issued while busy is held off.
- R11: While a received byte waits with rd_ready low, the serial clock stops before the next byte completes. No byte is lost or repeated.
- R12: The serial clock is low whenever chip select is high (mode 0). The serial clock runs at half the system clock, and input nibbles are taken on its rising edge.
- R13: After reset, chip select is high, the serial clock is low, io_oe is 0, rd_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read or exit request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 24 | Byte address of the read (low 4 bits ignored) |
| req_len | input | LEN_W | Number of bytes to read, at least 1 |
| req_keep | input | 1 | Leave the flash in continuous-read mode after this read |
| req_exit | input | 1 | Send the continuous-read exit sequence instead of a read |
| qspi_sclk | output | 1 | Serial clock |
| qspi_cs_n | output | 1 | Chip select, active low |
| qspi_io_out | output | 4 | Values driven onto io[3:0] |
| qspi_io_oe | output | 4 | Per-line output enable for io[3:0] |
| qspi_io_in | input | 4 | Values read from io[3:0] |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Received byte |

## Verification
The assertions assume that every read request has a nonzero byte count, that the client keeps the request fields stable while req_valid waits for req_ready, and that the flash drives the data lines only once the mode clocks are over. The bench's flash model decodes the address from the lines it samples and drives data only after the header length the bench expects. The stimulus draws lengths from 1 to 8, changes request fields only while no request is pending, and toggles rd_ready at random so that the clock-stall path is exercised without exceeding these limits.

// File: rtl/qspi_xip_pkg.sv
// Shared types and constants for the quad SPI read sequencer.
// Assumes: the flash's quad-enable setting is already made elsewhere.
package qspi_xip_pkg;

    // Transaction phases of the sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DATA,
        ST_EXIT,
        ST_GAP
    } seq_state_t;

    // How many data lines the transmit shifter drives.
    typedef enum logic [1:0] {
        LANE_OFF,
        LANE_ONE,
        LANE_FOUR
    } lane_t;

    localparam logic [7:0] OP_QUAD_READ = 8'hE3;
    localparam logic [7:0] OP_LEAVE     = 8'hFF;
    localparam logic [7:0] MODE_STAY    = 8'h20;
    localparam logic [7:0] MODE_NORMAL  = 8'h00;

endpackage

// File: rtl/qspi_sclk_gen.sv
// Serial clock phase generator: divides the system clock by two while a
// transaction runs and parks low otherwise (SPI mode 0).
// Assumes: 'hold' only freezes the clock and never pulses 'run'.
module qspi_sclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    output logic sclk,
    output logic rise,
    output logic fall
);

    logic ph;

    // Toggle the phase every system clock while running and not held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= 1'b0;
        end else if (!run) begin
            ph <= 1'b0;
        end else if (!hold) begin
            ph <= ~ph;
        end
    end

    assign sclk = ph;
    assign rise = run && !hold && !ph;
    assign fall = run && !hold && ph;

    AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !sclk); // R12

endmodule

// File: rtl/qspi_tx_shifter.sv
// Transmit shift register: holds the command or header word and presents
// it on one line (MSB on io[0]) or four lines (top nibble on io[3:0]).
// Assumes: 'load' has priority over 'shift'; lane selects width per clock.
module qspi_tx_shifter
    import qspi_xip_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  lane_t             lane,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe
);

    logic [WORD_W-1:0] sreg;

    // Load a new word or advance by one bit or one nibble per serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_word;
        end else if (shift) begin
            case (lane)
                LANE_ONE:  sreg <= sreg << 1;
                LANE_FOUR: sreg <= sreg << 4;
                default:   sreg <= sreg;
            endcase
        end
    end

    // Map the register head onto the data lines and their enables.
    always_comb begin
        case (lane)
            LANE_ONE: begin
                io_out = {3'b000, sreg[WORD_W-1]};
                io_oe  = 4'b0001;
            end
            LANE_FOUR: begin
                io_out = sreg[WORD_W-1 -: 4];
                io_oe  = 4'b1111;
            end
            default: begin
                io_out = 4'b0000;
                io_oe  = 4'b0000;
            end
        endcase
    end

endmodule

// File: rtl/qspi_rx_packer.sv
// Receive packer: joins two nibbles (high first) into a byte and offers it
// on a one-entry valid/ready output; requests a clock stall when full.
// Assumes: 'sample' pulses only on serial clock rising edges in the data phase.
module qspi_rx_packer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       sample,
    input  logic [3:0] io_in,
    input  logic       rd_ready,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       stall
);

    logic       want_hi;
    logic [3:0] nib_hi;
    logic       capture_byte;

    assign capture_byte = sample && !want_hi;

    // Track which half of the byte the next nibble fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_hi <= 1'b1;
            nib_hi  <= 4'h0;
        end else if (start) begin
            want_hi <= 1'b1;
        end else if (sample) begin
            if (want_hi) begin
                nib_hi  <= io_in;
                want_hi <= 1'b0;
            end else begin
                want_hi <= 1'b1;
            end
        end
    end

    // Hold a completed byte until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else if (capture_byte) begin
            rd_valid <= 1'b1;
            rd_data  <= {nib_hi, io_in};
        end else if (rd_ready) begin
            rd_valid <= 1'b0;
        end
    end

    assign stall = !want_hi && rd_valid && !rd_ready;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        capture_byte |-> !(rd_valid && !rd_ready)); // R11

endmodule

// File: rtl/qspi_xip_reader.sv
// Quad SPI execute-in-place read sequencer (top). Runs one framed read per
// request: optional command byte, aligned address, mode byte, data. Keeps a
// flag for the flash's continuous-read state and can send the exit sequence.
// Assumes: req_len is nonzero for reads; request fields are stable while
// req_valid is high; MIN_GAP is at least 2.
module qspi_xip_reader
    import qspi_xip_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int MIN_GAP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_keep,
    input  logic             req_exit,
    output logic             qspi_sclk,
    output logic             qspi_cs_n,
    output logic [3:0]       qspi_io_out,
    output logic [3:0]       qspi_io_oe,
    input  logic [3:0]       qspi_io_in,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data
);

    localparam int               CNT_W      = LEN_W + 1;
    localparam logic [CNT_W-1:0] BYTE_CLKS  = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_CLKS  = CNT_W'(5);
    localparam logic [CNT_W-1:0] MODE_CLKS  = CNT_W'(1);
    localparam logic [CNT_W-1:0] GAP_LOAD   = CNT_W'(MIN_GAP - 2);
    localparam logic [23:0]      ALIGN_MASK = 24'hFF_FFF0;

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [31:0]      hdr_word;
    logic [LEN_W-1:0] len_q;
    logic             keep_q;
    logic             cont_q;

    logic        run, hold, rise, fall;
    logic        accept, tx_load, tx_shift, rx_stall, rx_sample;
    logic [31:0] tx_word;
    logic [31:0] new_hdr;
    lane_t       lane;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign req_ready = (state == ST_IDLE);
    assign run       = (state != ST_IDLE) && (state != ST_GAP);
    assign qspi_cs_n = !run;
    assign hold      = (state == ST_DATA) && rx_stall;
    assign rx_sample = rise && (state == ST_DATA);

    // Build the address-plus-mode word from the incoming request.
    always_comb begin
        new_hdr = {req_addr & ALIGN_MASK, req_keep ? MODE_STAY : MODE_NORMAL};
    end

    // Choose what the transmit shifter loads and when it advances.
    always_comb begin
        tx_load = 1'b0;
        tx_word = hdr_word;
        if (accept) begin
            tx_load = 1'b1;
            if (req_exit) begin
                tx_word = {OP_LEAVE, 24'h0};
            end else if (cont_q) begin
                tx_word = new_hdr;
            end else begin
                tx_word = {OP_QUAD_READ, 24'h0};
            end
        end else if ((state == ST_CMD) && fall && (cnt == '0)) begin
            tx_load = 1'b1;
            tx_word = hdr_word;
        end
        tx_shift = fall && !tx_load;
    end

    // Select the line width for the current phase.
    always_comb begin
        case (state)
            ST_CMD, ST_EXIT:  lane = LANE_ONE;
            ST_ADDR, ST_MODE: lane = LANE_FOUR;
            default:          lane = LANE_OFF;
        endcase
    end

    // Phase sequencing, clock counting and continuous-read tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            hdr_word <= '0;
            len_q    <= '0;
            keep_q   <= 1'b0;
            cont_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        hdr_word <= new_hdr;
                        len_q    <= req_len;
                        keep_q   <= req_keep;
                        if (req_exit) begin
                            state <= ST_EXIT;
                            cnt   <= BYTE_CLKS;
                        end else if (cont_q) begin
                            state <= ST_ADDR;
                            cnt   <= ADDR_CLKS;
                        end else begin
                            state <= ST_CMD;
                            cnt   <= BYTE_CLKS;
                        end
                    end
                end
                ST_CMD: begin
                    if (fall) begin
                        if (cnt == '0) begin
                            state <= ST_ADDR;
                            cnt   <= ADDR_CLKS;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (fall) begin
                        if (cnt == '0) begin
                            state <= ST_MODE;
                            cnt   <= MODE_CLKS;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_MODE: begin
                    if (fall) begin
                        if (cnt == '0) begin
                            state  <= ST_DATA;
                            cnt    <= {len_q, 1'b0} - 1'b1;
                            cont_q <= keep_q;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        if (cnt == '0) begin
                            state <= ST_GAP;
                            cnt   <= GAP_LOAD;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_EXIT: begin
                    if (fall) begin
                        if (cnt == '0) begin
                            state  <= ST_GAP;
                            cnt    <= GAP_LOAD;
                            cont_q <= 1'b0;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    qspi_sclk_gen u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .hold  (hold),
        .sclk  (qspi_sclk),
        .rise  (rise),
        .fall  (fall)
    );

    qspi_tx_shifter #(.WORD_W(32)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_word (tx_word),
        .shift     (tx_shift),
        .lane      (lane),
        .io_out    (qspi_io_out),
        .io_oe     (qspi_io_oe)
    );

    qspi_rx_packer u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .sample   (rx_sample),
        .io_in    (qspi_io_in),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .stall    (rx_stall)
    );

    AST_CMD_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CMD) || (state == ST_EXIT)) |-> (qspi_io_oe == 4'b0001)); // R1

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR) && (cnt == '0)) |-> (qspi_io_out == 4'h0)); // R3

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_exit) |-> (req_len != '0)); // R5

    AST_DATA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (qspi_io_oe == 4'b0000)); // R8

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qspi_cs_n) |=> qspi_cs_n); // R9

    AST_BUSY_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R10

endmodule

// File: tb/qspi_xip_reader_bench.sv
`timescale 1ns/1ps
module qspi_xip_reader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        req_keep = 1'b0;
    logic        req_exit = 1'b0;
    logic        qspi_sclk, qspi_cs_n;
    logic [3:0]  qspi_io_out, qspi_io_oe;
    logic [3:0]  qspi_io_in = 4'h0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;

    always #2 clk = ~clk;

    qspi_xip_reader u_qspi_xip_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .req_keep    (req_keep),
        .req_exit    (req_exit),
        .qspi_sclk   (qspi_sclk),
        .qspi_cs_n   (qspi_cs_n),
        .qspi_io_out (qspi_io_out),
        .qspi_io_oe  (qspi_io_oe),
        .qspi_io_in  (qspi_io_in),
        .rd_valid    (rd_valid),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int bp_mode = 0;
    int model_hdr = 99;
    int nclk = 0;
    logic [3:0] s_io [0:31];
    logic [3:0] s_oe [0:31];
    logic [7:0] got [0:511];
    int got_cnt = 0;
    bit exp_cont = 0;
    int oe_viol = 0, gap_viol = 0, ready_viol = 0, park_viol = 0;
    int hi_run = 0;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Flash model: record lines on rising serial clock, drive data on falling.
    always @(negedge qspi_cs_n) nclk = 0;

    always @(posedge qspi_sclk) begin
        if (!qspi_cs_n) begin
            if (nclk < 32) begin
                s_io[nclk] = qspi_io_out;
                s_oe[nclk] = qspi_io_oe;
            end
            if (nclk >= model_hdr && qspi_io_oe != 4'h0) oe_viol++;
            nclk++;
        end
    end

    always @(negedge qspi_sclk) begin
        if (!qspi_cs_n && nclk >= model_hdr && model_hdr <= 16) begin
            int b, j;
            logic [23:0] a;
            logic [7:0] d;
            b = model_hdr - 8;
            j = nclk - model_hdr;
            a = {s_io[b], s_io[b+1], s_io[b+2], s_io[b+3], s_io[b+4], s_io[b+5]};
            a = a + 24'(j / 2);
            d = mem_byte(a);
            qspi_io_in = (j % 2 == 0) ? d[7:4] : d[3:0];
        end
    end

    // Byte stream capture and consumer readiness.
    always @(posedge clk) begin
        if (rd_valid && rd_ready && got_cnt < 512) begin
            got[got_cnt] = rd_data;
            got_cnt++;
        end
    end

    always @(negedge clk) begin
        if (bp_mode == 0) rd_ready = 1'b1;
        else if (bp_mode == 1) rd_ready = ($urandom % 3) != 0;
        else rd_ready = 1'b0;
    end

    // Protocol monitors for R8, R9, R10, R12.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!qspi_cs_n && req_ready) ready_viol++;
            if (qspi_cs_n && qspi_sclk) park_viol++;
            if (qspi_cs_n) hi_run++;
            else begin
                if (hi_run > 0 && hi_run < 2) gap_viol++;
                hi_run = 0;
            end
        end
    end

    task automatic issue(input logic [23:0] a, input int len, input bit keep, input bit ex);
        @(negedge clk);
        req_addr = a; req_len = 8'(len); req_keep = keep; req_exit = ex;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [23:0] a, input int len, input bit keep, input int bp);
        int hdr, b, bad;
        logic [23:0] ea, sa;
        hdr = exp_cont ? 8 : 16;
        model_hdr = hdr;
        got_cnt = 0;
        bp_mode = bp;
        issue(a, len, keep, 1'b0);
        if (bp == 2) begin
            int n0;
            while (!rd_valid) @(negedge clk);
            repeat (4) @(negedge clk);
            n0 = nclk;
            repeat (20) @(negedge clk);
            chk(nclk == n0, "R11", "serial clock held while byte waits", nclk, n0);
            chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
            bp_mode = 0;
        end
        do @(negedge clk); while (!(got_cnt >= len && qspi_cs_n && req_ready));
        bp_mode = 0;
        if (exp_cont)
            chk(nclk == hdr + 2*len, "R6", "short read clock count", nclk, hdr + 2*len);
        else
            chk(nclk == hdr + 2*len, "R5", "full read clock count", nclk, hdr + 2*len);
        if (!exp_cont) begin
            logic [7:0] op;
            bad = 0;
            for (int i = 0; i < 8; i++) begin
                op[7-i] = s_io[i][0];
                if (s_oe[i] != 4'b0001) bad++;
            end
            chk(op == 8'hE3 && bad == 0, "R1", "command byte", op, 8'hE3);
        end
        b = hdr - 8;
        ea = a & 24'hFFFFF0;
        sa = {s_io[b], s_io[b+1], s_io[b+2], s_io[b+3], s_io[b+4], s_io[b+5]};
        bad = 0;
        for (int i = 0; i < 8; i++) if (s_oe[b+i] != 4'hF) bad++;
        chk(sa[23:4] == ea[23:4] && bad == 0, "R2", "address nibbles", sa, ea);
        chk(s_io[b+5] == 4'h0, "R3", "low address nibble", s_io[b+5], 0);
        chk({s_io[b+6], s_io[b+7]} == (keep ? 8'h20 : 8'h00), "R4", "mode byte",
            {s_io[b+6], s_io[b+7]}, keep ? 8'h20 : 8'h00);
        bad = 0;
        for (int i = 0; i < len; i++)
            if (got[i] !== mem_byte(ea + 24'(i))) bad++;
        chk(bad == 0 && got_cnt == len, "R5", "data bytes", got_cnt, len);
        exp_cont = keep;
    endtask

    task automatic do_exit();
        int bad;
        model_hdr = 99;
        got_cnt = 0;
        issue(24'h0, 1, 1'b0, 1'b1);
        do @(negedge clk); while (!(qspi_cs_n && req_ready));
        bad = 0;
        for (int i = 0; i < 8; i++)
            if (s_io[i][0] != 1'b1 || s_oe[i] != 4'b0001) bad++;
        chk(nclk == 8 && bad == 0, "R7", "exit sequence", nclk, 8);
        exp_cont = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(qspi_cs_n == 1'b1 && qspi_sclk == 1'b0, "R13", "idle bus", {qspi_cs_n, qspi_sclk}, 2'b10);
        chk(qspi_io_oe == 4'h0 && rd_valid == 1'b0, "R13", "idle enables", {qspi_io_oe, rd_valid}, 0);
        chk(req_ready == 1'b1, "R13", "ready after reset", req_ready, 1);

        do_read(24'h12345F, 4, 1'b0, 0);    // R3 round-down
        do_read(24'h000010, 1, 1'b1, 0);
        do_read(24'hABCDE0, 3, 1'b1, 0);    // R6 shortened
        do_read(24'hFFFFF0, 2, 1'b0, 0);    // shortened, leaves mode
        do_read(24'h100000, 2, 1'b0, 0);    // R7 full again
        do_read(24'h0A0A00, 5, 1'b1, 0);
        do_exit();                           // R7
        do_read(24'h777770, 2, 1'b0, 0);    // R7 full after exit
        do_read(24'h040000, 4, 1'b0, 2);    // R11 stall, R10 hold-off

        for (int k = 0; k < 25; k++) begin
            if ($urandom % 6 == 0) do_exit();
            else do_read(24'($urandom), 1 + ($urandom % 8), 1'($urandom % 2), 1);
        end

        chk(oe_viol == 0, "R8", "enables during data", oe_viol, 0);
        chk(gap_viol == 0, "R9", "chip select gap", gap_viol, 0);
        chk(ready_viol == 0, "R10", "ready while selected", ready_viol, 0);
        chk(park_viol == 0, "R12", "clock high while deselected", park_viol, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule